// File: doc/BRIEF.md
# CCD Front-End Control Core

This block is the digital control side of a CCD analog front end. A three-wire serial port (data bit, shift clock, load strobe) carries 16-bit frames. Each frame holds a 4-bit register address and 12 data bits. The frames configure a 10-bit amplifier gain code, one active-polarity bit for each of four timing pulses (reference sample, data sample, dummy-pixel clamp, optical-black clamp) and a conversion-clock source select.

All pins are oversampled by a single system clock `clk` through synchronizer chains. The incoming timing pulses are turned into active-high internal signals according to the stored polarity bits. The dummy-pixel clamp enable is derived from them. The conversion clock comes either from the external master clock or from the sample pulses. On each rising edge of the conversion clock the 10-bit converter result is latched, or forced to zero while preblanking is requested. A fixed-point monitor reports the gain in dB.

Three state machines carry the control flow:
- The serial receiver has the states RX_IDLE, RX_SHIFT and RX_FULL. Its transitions are:
  - IDLE to SHIFT on the first shift edge.
  - SHIFT to FULL on the sixteenth shift edge.
  - Any state to IDLE on a load edge. The frame is committed only when the load edge comes from FULL.
- The conversion-clock generator has the states CK_LOW and CK_HIGH.
  - In external mode the state follows the synchronized master clock.
  - In internal mode it goes LOW to HIGH on the trailing edge of the active data pulse.
  - In internal mode it goes HIGH to LOW on the trailing edge of the active reference pulse.
- The LOW to HIGH transition is the latch event.

Top module: `afe_ctrl_core`

## Requirements
- R1: After reset the gain code is 128, the dB monitor reads 0, all four polarity bits are 0 (active low), the clock mode is external, `conv_clk_o` is 0, `dout_o` is 0 and the clamp enable is 0.
- R2: On each rising edge of `ser_clk_i` one bit of `ser_dat_i` is shifted in, MSB first. A rising edge of `ser_load_i` commits a 16-bit frame, where bits [15:12] are the address and bits [11:0] are the data. Address 0 loads the gain code from data[9:0].
- R3: A load edge that comes after fewer than 16 shift edges since the previous load or reset is discarded and restarts the count. When more than 16 bits were shifted, the last 16 form the frame.
- R4: A committed frame with an address from 3 to 15 changes neither the gain, nor the polarities, nor the clock mode.
- R5: Address 1 data[3:0] sets the polarities: bit0 reference, bit1 data, bit2 dummy clamp, bit3 black clamp, where 1 means active high. `ref_act_o`, `dat_act_o` and `blk_act_o` are 1 exactly while their pin is at its active level.
- R6: `dmy_clamp_o` is 1 only while both the dummy-clamp pulse and the reference pulse are at their active levels.
- R7: Address 2 data[0] selects the clock mode. With 0, `conv_clk_o` follows `adc_mclk_i`. With 1, it rises on the trailing edge of the active data pulse, falls on the trailing edge of the active reference pulse, and ignores `adc_mclk_i`.
- R8: On a rising edge of `conv_clk_o` with `pblank_n_i` high, `dout_o` takes `adc_data_i`. At no other time does `dout_o` change.
- R9: On a rising edge of `conv_clk_o` with `pblank_n_i` low, `dout_o` becomes all zeros.
- R10: `gain_db_o` equals gain_code*48 - 6144 as a signed value in units of 1/1024 dB. For example, code 1023 gives 42960.
- R11: Driving `rst_n` low at any time returns every configuration field to its R1 default at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock |
| ser_dat_i | input | 1 | Serial data bit |
| ser_load_i | input | 1 | Serial load strobe |
| ref_pulse_i | input | 1 | Reference-sample pulse pin |
| dat_pulse_i | input | 1 | Data-sample pulse pin |
| dmy_pulse_i | input | 1 | Dummy-pixel clamp pulse pin |
| blk_pulse_i | input | 1 | Optical-black clamp pulse pin |
| adc_mclk_i | input | 1 | External master conversion clock |
| pblank_n_i | input | 1 | Preblanking, low forces zero output |
| adc_data_i | input | 10 | Converter result |
| ref_act_o | output | 1 | Reference pulse, active high |
| dat_act_o | output | 1 | Data pulse, active high |
| blk_act_o | output | 1 | Black clamp pulse, active high |
| dmy_clamp_o | output | 1 | Dummy-pixel clamp enable |
| conv_clk_o | output | 1 | Selected conversion clock |
| dout_o | output | 10 | Latched digital output |
| gain_code_o | output | 10 | Active gain code |
| gain_db_o | output | 17 | Signed gain in 1/1024 dB |

## Verification
Every pin passes two synchronizer stages before it is used. A committed frame therefore reaches the configuration registers on the fourth `clk` edge after the load pin rises. Normalized pulse outputs and the clamp enable follow a pin on the third edge. The conversion clock and the output latch follow a master-clock edge on the third edge, and a trailing sample-pulse edge on the fourth. The bench changes pins only on falling clock edges, waits at least eight cycles for each result, and samples on a falling edge. Each expected value is therefore already settled when it is read and cannot be confused with the next stimulus.

// File: rtl/afe_ctrl_pkg.sv
package afe_ctrl_pkg;

    localparam int ADDR_W       = 4;
    localparam int DATA_W       = 12;
    localparam int FRAME_W      = ADDR_W + DATA_W;
    localparam int GAIN_W       = 10;
    localparam int NPOL         = 4;
    localparam int GAIN_DEFAULT = 128;

    localparam int ADDR_GAIN = 0;
    localparam int ADDR_POL  = 1;
    localparam int ADDR_MODE = 2;

    // index of each pulse inside the polarity field
    localparam int PI_REF = 0;
    localparam int PI_DAT = 1;
    localparam int PI_DMY = 2;
    localparam int PI_BLK = 3;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_SHIFT = 2'd1,
        RX_FULL  = 2'd2
    } rx_state_t;

    typedef enum logic {
        CK_LOW  = 1'b0,
        CK_HIGH = 1'b1
    } ck_state_t;

endpackage

// File: rtl/afe_serial_rx.sv
module afe_serial_rx
    import afe_ctrl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int AW          = ADDR_W,
    parameter int DW          = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ser_clk_i,
    input  logic          ser_dat_i,
    input  logic          ser_load_i,
    output logic          commit_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o
);

    localparam int FW    = AW + DW;
    localparam int CNT_W = $clog2(FW + 1);

    // synchronizer: bit2 load, bit1 data, bit0 shift clock
    logic [2:0] sync_q [SYNC_STAGES];
    logic       sclk_prev_q;
    logic       load_prev_q;
    logic       sclk_s, dat_s, load_s;
    logic       shift_evt, load_evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
            sclk_prev_q <= 1'b0;
            load_prev_q <= 1'b0;
        end else begin
            sync_q[0] <= {ser_load_i, ser_dat_i, ser_clk_i};
            for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
            sclk_prev_q <= sclk_s;
            load_prev_q <= load_s;
        end
    end

    assign sclk_s    = sync_q[SYNC_STAGES-1][0];
    assign dat_s     = sync_q[SYNC_STAGES-1][1];
    assign load_s    = sync_q[SYNC_STAGES-1][2];
    assign shift_evt = sclk_s & ~sclk_prev_q;
    assign load_evt  = load_s & ~load_prev_q;

    rx_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [FW-1:0]    sr_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: begin
                if (load_evt)       state_d = RX_IDLE;
                else if (shift_evt) state_d = RX_SHIFT;
            end
            RX_SHIFT: begin
                if (load_evt)
                    state_d = RX_IDLE;
                else if (shift_evt && cnt_q == CNT_W'(FW - 1))
                    state_d = RX_FULL;
            end
            RX_FULL: begin
                if (load_evt) state_d = RX_IDLE;
            end
            default: state_d = RX_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            sr_q     <= '0;
            commit_o <= 1'b0;
            addr_o   <= '0;
            data_o   <= '0;
        end else begin
            commit_o <= 1'b0;
            if (load_evt) begin
                cnt_q <= '0;
                if (state_q == RX_FULL) begin
                    commit_o <= 1'b1;
                    addr_o   <= sr_q[FW-1:DW];
                    data_o   <= sr_q[DW-1:0];
                end
            end else if (shift_evt) begin
                sr_q <= {sr_q[FW-2:0], dat_s};
                if (state_q != RX_FULL) cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    AST_COMMIT_BACK_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> state_q == RX_IDLE);  // R2
    AST_COMMIT_NEEDS_FULL_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> $past(cnt_q) == CNT_W'(FW));  // R3

endmodule

// File: rtl/afe_cfg_regs.sv
module afe_cfg_regs
    import afe_ctrl_pkg::*;
#(
    parameter int AW   = ADDR_W,
    parameter int DW   = DATA_W,
    parameter int GW   = GAIN_W,
    parameter int NP   = NPOL,
    parameter int GDEF = GAIN_DEFAULT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_i,
    input  logic [AW-1:0]        addr_i,
    input  logic [DW-1:0]        data_i,
    output logic [GW-1:0]        gain_o,
    output logic [NP-1:0]        pol_o,
    output logic                 mode_int_o,
    output logic signed [GW+6:0] gain_db_o
);

    localparam int DBW = GW + 7;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gain_o     <= GW'(GDEF);
            pol_o      <= '0;
            mode_int_o <= 1'b0;
        end else if (wr_i) begin
            if (addr_i == AW'(ADDR_GAIN)) gain_o     <= data_i[GW-1:0];
            if (addr_i == AW'(ADDR_POL))  pol_o      <= data_i[NP-1:0];
            if (addr_i == AW'(ADDR_MODE)) mode_int_o <= data_i[0];
        end
    end

    // dB monitor: code*48/2^GW - 6, scaled by 2^GW
    logic [DBW-1:0] prod;
    assign prod      = DBW'(gain_o) * DBW'(48);
    assign gain_db_o = $signed(prod - DBW'(6 << GW));

    logic unused_hi;
    assign unused_hi = ^data_i[DW-1:GW];

    AST_GAIN_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gain_o) |-> $past(wr_i && addr_i == AW'(ADDR_GAIN)));  // R2
    AST_UNDEF_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_i && addr_i > AW'(ADDR_MODE)) |->
            ($stable(gain_o) && $stable(pol_o) && $stable(mode_int_o)));  // R4

endmodule

// File: rtl/afe_timing.sv
module afe_timing
    import afe_ctrl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int NP          = NPOL
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_i,
    input  logic          dat_i,
    input  logic          dmy_i,
    input  logic          blk_i,
    input  logic          mclk_i,
    input  logic [NP-1:0] pol_i,
    input  logic          mode_int_i,
    output logic          ref_act_o,
    output logic          dat_act_o,
    output logic          blk_act_o,
    output logic          dmy_clamp_o,
    output logic          conv_clk_o,
    output logic          conv_rise_o
);

    localparam int SW = NP + 1;
    localparam logic [SW-1:0] SYNC_RST = {1'b0, {NP{1'b1}}};

    logic [SW-1:0] sync_q [SYNC_STAGES];
    logic [SW-1:0] s;
    logic [NP-1:0] act_d, act_q;
    logic [1:0]    trail_prev_q;
    logic          dat_trail, ref_trail;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= SYNC_RST;
        end else begin
            sync_q[0] <= {mclk_i, blk_i, dmy_i, dat_i, ref_i};
            for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
        end
    end

    assign s = sync_q[SYNC_STAGES-1];

    // polarity normalization, one lane per pulse
    for (genvar g = 0; g < NP; g++) begin : g_norm
        assign act_d[g] = pol_i[g] ? s[g] : ~s[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q        <= '0;
            trail_prev_q <= '0;
            dmy_clamp_o  <= 1'b0;
        end else begin
            act_q        <= act_d;
            trail_prev_q <= {act_q[PI_DAT], act_q[PI_REF]};
            dmy_clamp_o  <= act_d[PI_DMY] & act_d[PI_REF];
        end
    end

    assign ref_act_o = act_q[PI_REF];
    assign dat_act_o = act_q[PI_DAT];
    assign blk_act_o = act_q[PI_BLK];
    assign dat_trail = trail_prev_q[1] & ~act_q[PI_DAT];
    assign ref_trail = trail_prev_q[0] & ~act_q[PI_REF];

    ck_state_t ck_q, ck_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ck_q <= CK_LOW;
        else        ck_q <= ck_d;
    end

    always_comb begin
        ck_d = ck_q;
        if (mode_int_i) begin
            unique case (ck_q)
                CK_LOW:  if (dat_trail) ck_d = CK_HIGH;
                CK_HIGH: if (ref_trail) ck_d = CK_LOW;
                default: ck_d = CK_LOW;
            endcase
        end else begin
            ck_d = s[NP] ? CK_HIGH : CK_LOW;
        end
    end

    assign conv_clk_o  = (ck_q == CK_HIGH);
    assign conv_rise_o = (ck_q == CK_LOW) && (ck_d == CK_HIGH);

    AST_CLAMP_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        dmy_clamp_o |-> (act_q[PI_DMY] && act_q[PI_REF]));  // R6
    AST_INT_CLK_FROM_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_int_i) && mode_int_i && conv_clk_o != $past(conv_clk_o))
            |-> $past(dat_trail || ref_trail));  // R7

endmodule

// File: rtl/afe_out_latch.sv
module afe_out_latch #(
    parameter int DOUT_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_i,
    input  logic              pblank_n_i,
    input  logic [DOUT_W-1:0] adc_i,
    output logic [DOUT_W-1:0] dout_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       dout_o <= '0;
        else if (latch_i) dout_o <= pblank_n_i ? adc_i : '0;
    end

    AST_DOUT_ONLY_ON_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout_o) |-> $past(latch_i));  // R8
    AST_PBLANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(latch_i && !pblank_n_i) |-> dout_o == '0);  // R9

endmodule

// File: rtl/afe_ctrl_core.sv
module afe_ctrl_core
    import afe_ctrl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DOUT_W      = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ser_clk_i,
    input  logic                     ser_dat_i,
    input  logic                     ser_load_i,
    input  logic                     ref_pulse_i,
    input  logic                     dat_pulse_i,
    input  logic                     dmy_pulse_i,
    input  logic                     blk_pulse_i,
    input  logic                     adc_mclk_i,
    input  logic                     pblank_n_i,
    input  logic [DOUT_W-1:0]        adc_data_i,
    output logic                     ref_act_o,
    output logic                     dat_act_o,
    output logic                     blk_act_o,
    output logic                     dmy_clamp_o,
    output logic                     conv_clk_o,
    output logic [DOUT_W-1:0]        dout_o,
    output logic [GAIN_W-1:0]        gain_code_o,
    output logic signed [GAIN_W+6:0] gain_db_o
);

    logic              commit;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [NPOL-1:0]   pol;
    logic              mode_int;
    logic              conv_rise;

    afe_serial_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_clk_i  (ser_clk_i),
        .ser_dat_i  (ser_dat_i),
        .ser_load_i (ser_load_i),
        .commit_o   (commit),
        .addr_o     (addr),
        .data_o     (data)
    );

    afe_cfg_regs u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (commit),
        .addr_i     (addr),
        .data_i     (data),
        .gain_o     (gain_code_o),
        .pol_o      (pol),
        .mode_int_o (mode_int),
        .gain_db_o  (gain_db_o)
    );

    afe_timing #(.SYNC_STAGES(SYNC_STAGES)) u_tim (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_i       (ref_pulse_i),
        .dat_i       (dat_pulse_i),
        .dmy_i       (dmy_pulse_i),
        .blk_i       (blk_pulse_i),
        .mclk_i      (adc_mclk_i),
        .pol_i       (pol),
        .mode_int_i  (mode_int),
        .ref_act_o   (ref_act_o),
        .dat_act_o   (dat_act_o),
        .blk_act_o   (blk_act_o),
        .dmy_clamp_o (dmy_clamp_o),
        .conv_clk_o  (conv_clk_o),
        .conv_rise_o (conv_rise)
    );

    afe_out_latch #(.DOUT_W(DOUT_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .latch_i    (conv_rise),
        .pblank_n_i (pblank_n_i),
        .adc_i      (adc_data_i),
        .dout_o     (dout_o)
    );

endmodule

// File: tb/tb_afe_ctrl_core.sv
`timescale 1ns/1ps
module tb_afe_ctrl_core;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_load = 1'b0;
    logic ref_p = 1'b1, dat_p = 1'b1, dmy_p = 1'b1, blk_p = 1'b1;
    logic mclk = 1'b0, pblank_n = 1'b1;
    logic [9:0] adc = '0;
    logic ref_act, dat_act, blk_act, dmy_clamp, conv_clk;
    logic [9:0] dout, gain;
    logic signed [16:0] gain_db;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    afe_ctrl_core dut (
        .clk(clk), .rst_n(rst_n),
        .ser_clk_i(ser_clk), .ser_dat_i(ser_dat), .ser_load_i(ser_load),
        .ref_pulse_i(ref_p), .dat_pulse_i(dat_p), .dmy_pulse_i(dmy_p),
        .blk_pulse_i(blk_p), .adc_mclk_i(mclk), .pblank_n_i(pblank_n),
        .adc_data_i(adc),
        .ref_act_o(ref_act), .dat_act_o(dat_act), .blk_act_o(blk_act),
        .dmy_clamp_o(dmy_clamp), .conv_clk_o(conv_clk), .dout_o(dout),
        .gain_code_o(gain), .gain_db_o(gain_db)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bit(logic b);
        ser_dat = b;
        wait_n(3);
        ser_clk = 1'b1;
        wait_n(3);
        ser_clk = 1'b0;
        wait_n(3);
    endtask

    task automatic load_pulse();
        ser_load = 1'b1;
        wait_n(4);
        ser_load = 1'b0;
        wait_n(6);
    endtask

    task automatic write_reg(int addr, int data);
        logic [15:0] f;
        f = {addr[3:0], data[11:0]};
        for (int i = 15; i >= 0; i--) shift_bit(f[i]);
        load_pulse();
    endtask

    task automatic set_and_settle(output logic sig, input logic v);
        sig = v;
        wait_n(8);
    endtask

    task automatic t_reset();
        wait_n(3);
        rst_n = 1'b1;
        wait_n(8);
        check("R1 gain", gain, 128);
        check("R1 db", gain_db, 0);
        check("R1 dout", dout, 0);
        check("R1 conv_clk", conv_clk, 0);
        check("R1 clamp", dmy_clamp, 0);
        check("R1 ref_act idle", ref_act, 0);
    endtask

    task automatic t_gain();
        write_reg(0, 1023);
        check("R2 gain 1023", gain, 1023);
        check("R10 db 1023", gain_db, 42960);
        write_reg(0, 0);
        check("R2 gain 0", gain, 0);
        check("R10 db 0", gain_db, -6144);
    endtask

    task automatic t_frames();
        for (int i = 0; i < 8; i++) shift_bit(1'b1);
        load_pulse();
        check("R3 short frame discarded", gain, 0);
        shift_bit(1'b1); shift_bit(1'b0); shift_bit(1'b1);
        write_reg(0, 12'h2A5);
        check("R3 long frame last 16", gain, 12'h2A5);
        check("R10 db 677", gain_db, 26352);
    endtask

    task automatic t_bad_addr();
        write_reg(3, 12'h001);
        write_reg(15, 12'h3FF);
        write_reg(7, 12'h00F);
        check("R4 gain kept", gain, 12'h2A5);
        check("R4 pol kept", ref_act, 0);
        mclk = 1'b1; wait_n(8);
        check("R4 mode kept ext", conv_clk, 1);
        mclk = 1'b0; wait_n(8);
        check("R4 mode kept ext low", conv_clk, 0);
    endtask

    task automatic t_clamp();
        dmy_p = 1'b0; ref_p = 1'b0; wait_n(8);
        check("R6 both active", dmy_clamp, 1);
        check("R5 ref active low", ref_act, 1);
        ref_p = 1'b1; wait_n(8);
        check("R6 ref idle", dmy_clamp, 0);
        dmy_p = 1'b1; ref_p = 1'b0; wait_n(8);
        check("R6 dummy idle", dmy_clamp, 0);
        ref_p = 1'b1; wait_n(8);
    endtask

    task automatic t_ext_clk();
        adc = 10'h155; pblank_n = 1'b1;
        mclk = 1'b1; wait_n(8);
        check("R7 ext conv high", conv_clk, 1);
        check("R8 latch data", dout, 10'h155);
        adc = 10'h2AA; wait_n(4);
        mclk = 1'b0; wait_n(8);
        check("R8 no latch on fall", dout, 10'h155);
        pblank_n = 1'b0; adc = 10'h3FF;
        mclk = 1'b1; wait_n(8);
        check("R9 preblank zero", dout, 0);
        mclk = 1'b0; wait_n(8);
        pblank_n = 1'b1;
        wait_n(8);
        check("R8 pblank alone no change", dout, 0);
    endtask

    task automatic t_int_clk();
        write_reg(2, 1);
        check("R7 int starts low", conv_clk, 0);
        adc = 10'h0F0;
        dat_p = 1'b0; wait_n(8);
        check("R7 no rise on leading", conv_clk, 0);
        dat_p = 1'b1; wait_n(8);
        check("R7 rise on data trail", conv_clk, 1);
        check("R8 int latch", dout, 10'h0F0);
        mclk = 1'b1; wait_n(8);
        mclk = 1'b0; wait_n(8);
        check("R7 mclk ignored", conv_clk, 1);
        adc = 10'h00F;
        ref_p = 1'b0; wait_n(8);
        check("R7 hold before ref trail", conv_clk, 1);
        ref_p = 1'b1; wait_n(8);
        check("R7 fall on ref trail", conv_clk, 0);
        check("R8 no latch on int fall", dout, 10'h0F0);
    endtask

    task automatic t_polarity();
        write_reg(1, 12'h00F);
        check("R5 ref high active", ref_act, 1);
        check("R5 blk high active", blk_act, 1);
        check("R5 dat high active", dat_act, 1);
        blk_p = 1'b0; wait_n(8);
        check("R5 blk low inactive", blk_act, 0);
        check("R6 clamp high-active both", dmy_clamp, 1);
        dmy_p = 1'b0; wait_n(8);
        check("R6 clamp dummy inactive", dmy_clamp, 0);
        dmy_p = 1'b1; blk_p = 1'b1; wait_n(8);
    endtask

    task automatic t_async_reset();
        write_reg(0, 5);
        #3 rst_n = 1'b0;
        #1;
        check("R11 gain async", gain, 128);
        check("R11 db async", gain_db, 0);
        check("R11 ref_act async", ref_act, 0);
        check("R11 conv async", conv_clk, 0);
        @(negedge clk);
        rst_n = 1'b1;
        wait_n(8);
        check("R11 pol default", ref_act, 0);
        check("R11 dout default", dout, 0);
        mclk = 1'b1; wait_n(8);
        check("R11 mode default ext", conv_clk, 1);
        mclk = 1'b0; wait_n(8);
    endtask

    initial begin
        t_reset();
        t_gain();
        t_frames();
        t_bad_addr();
        t_clamp();
        t_ext_clk();
        t_int_clk();
        t_polarity();
        t_async_reset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule